// File: doc/BRIEF.md
# USB On-The-Go Control Register Unit

This block holds the main control word of a USB On-The-Go controller and turns it into the signals that the rest of the controller uses. Software reaches the word through a simple write/read bus at a single address. The block then drives the clock-gate enable for the controller, the VBUS power output pin and the request strobes to the host-negotiation and session-request engines. It also drives the accept level for a negotiation offered in host mode and five masked interrupt lines.

Fields obey different write rules. The enable and clock-hold fields can always be written. The VBUS polarity and pad enable fields can also always be written, and they keep their value when the controller is disabled. The remaining fields accept writes only while the controller is enabled and its clock is not held, and they are cleared whenever the controller is disabled. The two request fields clear themselves when the engine they address acknowledges. The VBUS pin combines a software-chosen polarity with an automatic, latched cutoff that a VBUS fault triggers.

Top module: `otg_ctl_regs`

## Requirements
- R1: The enable field (bit 0) and the clock-hold field (bit 1) take every bus write to the control address, in any state. `clk_run` is 1 exactly when enable is 1 and clock-hold is 0.
- R2: While clock-hold is 1, a write leaves bits 4 to 12 unchanged, and enable, clock-hold, polarity and pad enable still take the written values.
- R3: Polarity (bit 2) and pad enable (bit 3, driven on `pad_en`) take every write. A write that clears enable leaves them as written and clears bits 4 to 12 in the same cycle. While enable is 0, writes to bits 4 to 12 are ignored.
- R4: The logical VBUS drive is 1 when `host_mode`=1, enable=1 and no cutoff is latched. `vbus_pin` equals this drive when polarity is 0 and its inverse when polarity is 1.
- R5: In device mode (`host_mode`=0), writing 1 to the negotiation request field (bit 4) sets it and raises `hnp_start` for exactly the one cycle after the write. Writing 0 has no effect. `hnp_ack` high at a clock edge clears the field.
- R6: In host mode, the negotiation request field is a plain read/write bit, shown on `hnp_accept` (1 accepts, 0 rejects), and it produces no `hnp_start` pulse.
- R7: In device mode, writing 1 to the session request field (bit 5) sets it and raises `srp_start` for one cycle. Writing 0 has no effect, `srp_ack` clears the field, and in host mode writes to the field are ignored. `srp_method` shows the select field (bit 6): 0 selects data-line pulsing and 1 selects VBUS pulsing.
- R8: With the manual VBUS field (bit 7) at 0, `vbus_err` high at a clock edge while enabled latches the cutoff, and `vbus_pin` goes to its inactive level. With bit 7 at 1, `vbus_err` has no effect.
- R9: `irq_out[i]` equals `irq_src[i]` AND interrupt-enable bit 8+i, for i = 0 to 4. The sources are, in order: suspend time-out, negotiation error, role exchange, B-connection error, VBUS error.
- R10: After reset the control word reads 0x0002 (only clock-hold set), and all strobes and the cutoff are 0.
- R11: The cutoff stays latched after `vbus_err` falls. A write with bit 13 set clears it, provided the write is accepted for bits 4 to 12 and `vbus_err` is low. Bit 13 always reads 0.
- R12: Writes to any other address change nothing, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (control word at the control address, else 0) |
| host_mode | input | 1 | 1 = host role, 0 = device role |
| hnp_ack | input | 1 | Negotiation engine reports the request was initiated |
| srp_ack | input | 1 | Session engine reports the request was initiated |
| vbus_err | input | 1 | VBUS fault indication |
| irq_src | input | 5 | Raw interrupt events |
| vbus_pin | output | 1 | VBUS power output pin |
| clk_run | output | 1 | Clock-gate enable for the controller |
| hnp_start | output | 1 | One-cycle negotiation request strobe |
| srp_start | output | 1 | One-cycle session request strobe |
| hnp_accept | output | 1 | Host-mode acceptance of a negotiation |
| srp_method | output | 1 | Session request signalling method |
| pad_en | output | 1 | OTG pad enable |
| irq_out | output | 5 | Masked interrupt lines |

## Verification
The bench builds the block with a 16-bit data path, a 4-bit address and the control word at address 8. The narrow bus makes the zero-filled upper half of the read data visible and lets a write to address 3 show that other addresses are ignored. The vector table walks the word through frozen, enabled and disabled states so that each write rule is seen against the one before it. Directed cases then cover both roles for the request fields, the latched cutoff under both settings of the manual field, and the interrupt mask.

// File: rtl/otg_ctl_pkg.sv
package otg_ctl_pkg;

    localparam int N_IRQ    = 5;
    localparam int REG_BITS = 14;
    localparam int B_CUTCLR = 13;

    // Control word image, bit 0 = ctl_on, bits 12:8 = interrupt enables
    typedef struct packed {
        logic [N_IRQ-1:0] irq_en;
        logic             vbus_manual;
        logic             srp_vbus;
        logic             srp_req;
        logic             hnp_req;
        logic             pad_on;
        logic             vbus_inv;
        logic             clk_hold;
        logic             ctl_on;
    } ctl_reg_t;

    localparam int IMG_BITS = $bits(ctl_reg_t);

    function automatic ctl_reg_t unpack_word(input logic [REG_BITS-1:0] w);
        return ctl_reg_t'(w[IMG_BITS-1:0]);
    endfunction

    function automatic logic [REG_BITS-1:0] pack_word(input ctl_reg_t r);
        return {{(REG_BITS-IMG_BITS){1'b0}}, r};
    endfunction

endpackage

// File: rtl/otg_req_bit.sv
module otg_req_bit #(
    parameter bit HOST_RW = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic wr_ok,
    input  logic wbit,
    input  logic host_mode,
    input  logic ack,
    output logic q,
    output logic pulse
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q     <= 1'b0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (host_mode && HOST_RW) begin
                if (wr_ok) q <= wbit;
            end else if (ack) begin
                q <= 1'b0;
            end else if (wr_ok && wbit && !q && !host_mode) begin
                q     <= 1'b1;
                pulse <= 1'b1;
            end
        end
    end

    // R5
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    // R7
    pulse_has_bit_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |-> q);

endmodule

// File: rtl/otg_vbus_drive.sv
module otg_vbus_drive (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic manual,
    input  logic err,
    input  logic clr_req,
    input  logic host_mode,
    input  logic inv,
    output logic pin
);

    logic cut;

    always_ff @(posedge clk) begin
        if (rst || !enable)           cut <= 1'b0;
        else if (!manual && err)      cut <= 1'b1;
        else if (clr_req)             cut <= 1'b0;
    end

    assign pin = (host_mode && enable && !cut) ^ inv;

    // R8
    cut_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && !manual && err) |=> cut);

    // R11
    cut_latched_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && cut && !clr_req) |=> cut);

endmodule

// File: rtl/otg_irq_gate.sv
module otg_irq_gate #(
    parameter int N = 5
) (
    input  logic [N-1:0] src,
    input  logic [N-1:0] en,
    output logic [N-1:0] out
);

    for (genvar i = 0; i < N; i++) begin : g_line
        assign out[i] = src[i] & en[i];
    end

endmodule

// File: rtl/otg_ctl_regs.sv
module otg_ctl_regs
    import otg_ctl_pkg::*;
#(
    parameter int              DATA_W    = 32,
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              host_mode,
    input  logic              hnp_ack,
    input  logic              srp_ack,
    input  logic              vbus_err,
    input  logic [4:0]        irq_src,
    output logic              vbus_pin,
    output logic              clk_run,
    output logic              hnp_start,
    output logic              srp_start,
    output logic              hnp_accept,
    output logic              srp_method,
    output logic              pad_en,
    output logic [4:0]        irq_out
);

    localparam int PAD_W = DATA_W - REG_BITS;

    logic             ctl_on, clk_hold, vbus_inv, pad_on, srp_vbus, vbus_manual;
    logic [N_IRQ-1:0] irq_en;
    logic             hnp_q, srp_q;
    logic             wr, grp_ok, grp_clr, cut_clr;
    ctl_reg_t         w, cur;

    assign wr      = bus_we && (bus_addr == CTRL_ADDR);
    assign w       = unpack_word(bus_wdata[REG_BITS-1:0]);
    assign grp_ok  = wr && ctl_on && !clk_hold;
    assign grp_clr = wr ? !w.ctl_on : !ctl_on;
    assign cut_clr = grp_ok && bus_wdata[B_CUTCLR];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_on      <= 1'b0;
            clk_hold    <= 1'b1;
            vbus_inv    <= 1'b0;
            pad_on      <= 1'b0;
            srp_vbus    <= 1'b0;
            vbus_manual <= 1'b0;
            irq_en      <= '0;
        end else begin
            if (wr) begin
                ctl_on   <= w.ctl_on;
                clk_hold <= w.clk_hold;
                vbus_inv <= w.vbus_inv;
                pad_on   <= w.pad_on;
            end
            if (grp_clr) begin
                srp_vbus    <= 1'b0;
                vbus_manual <= 1'b0;
                irq_en      <= '0;
            end else if (grp_ok) begin
                srp_vbus    <= w.srp_vbus;
                vbus_manual <= w.vbus_manual;
                irq_en      <= w.irq_en;
            end
        end
    end

    otg_req_bit #(.HOST_RW(1'b1)) u_hnp (
        .clk(clk), .rst(rst), .clr(grp_clr), .wr_ok(grp_ok), .wbit(w.hnp_req),
        .host_mode(host_mode), .ack(hnp_ack), .q(hnp_q), .pulse(hnp_start)
    );

    otg_req_bit #(.HOST_RW(1'b0)) u_srp (
        .clk(clk), .rst(rst), .clr(grp_clr), .wr_ok(grp_ok), .wbit(w.srp_req),
        .host_mode(host_mode), .ack(srp_ack), .q(srp_q), .pulse(srp_start)
    );

    otg_vbus_drive u_vbus (
        .clk(clk), .rst(rst), .enable(ctl_on), .manual(vbus_manual),
        .err(vbus_err), .clr_req(cut_clr), .host_mode(host_mode),
        .inv(vbus_inv), .pin(vbus_pin)
    );

    otg_irq_gate #(.N(N_IRQ)) u_irq (
        .src(irq_src), .en(irq_en), .out(irq_out)
    );

    always_comb begin
        cur             = '0;
        cur.ctl_on      = ctl_on;
        cur.clk_hold    = clk_hold;
        cur.vbus_inv    = vbus_inv;
        cur.pad_on      = pad_on;
        cur.hnp_req     = hnp_q;
        cur.srp_req     = srp_q;
        cur.srp_vbus    = srp_vbus;
        cur.vbus_manual = vbus_manual;
        cur.irq_en      = irq_en;
    end

    assign bus_rdata  = (bus_addr == CTRL_ADDR) ? {{PAD_W{1'b0}}, pack_word(cur)} : '0;
    assign clk_run    = ctl_on && !clk_hold;
    assign hnp_accept = host_mode && hnp_q;
    assign srp_method = srp_vbus;
    assign pad_en     = pad_on;

    // R2
    frozen_grp_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && clk_hold && w.ctl_on) |=> ($stable(irq_en) && $stable(vbus_manual) && $stable(srp_vbus)));

    // R3
    disable_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && !w.ctl_on) |=> (irq_en == '0 && !hnp_q && !srp_q));

endmodule

// File: tb/otg_ctl_regs_bench.sv
module otg_ctl_regs_bench;

    localparam int DW = 16;
    localparam int AW = 4;
    localparam logic [AW-1:0] CA = 4'h8;
    localparam int NV = 7;

    // write word, expected read-back, expected clk_run (host mode)
    localparam logic [15:0] TBL_W [NV] = '{16'h1F0D, 16'h1FFD, 16'h00C3, 16'h1F11, 16'h0004, 16'h0009, 16'h0209};
    localparam logic [15:0] TBL_E [NV] = '{16'h000D, 16'h1FDD, 16'h00C3, 16'h00C1, 16'h0004, 16'h0009, 16'h0209};
    localparam logic        TBL_C [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};

    logic          clk = 1'b0, rst = 1'b1;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = CA;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          host_mode = 1'b1, hnp_ack = 1'b0, srp_ack = 1'b0, vbus_err = 1'b0;
    logic [4:0]    irq_src = '0, irq_out;
    logic          vbus_pin, clk_run, hnp_start, srp_start, hnp_accept, srp_method, pad_en;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    otg_ctl_regs #(.DATA_W(DW), .ADDR_W(AW), .CTRL_ADDR(CA)) u_otg_ctl_regs (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_mode(host_mode),
        .hnp_ack(hnp_ack), .srp_ack(srp_ack), .vbus_err(vbus_err),
        .irq_src(irq_src), .vbus_pin(vbus_pin), .clk_run(clk_run),
        .hnp_start(hnp_start), .srp_start(srp_start), .hnp_accept(hnp_accept),
        .srp_method(srp_method), .pad_en(pad_en), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [DW-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();
        // R10 reset state
        chk("R10 word", bus_rdata, 16'h0002);
        chk("R10 clk_run", clk_run, 0);
        chk("R10 strobes", {hnp_start, srp_start, vbus_pin}, 0);

        // R1 R2 R3 table walk in host mode
        for (int i = 0; i < NV; i++) begin
            wr(TBL_W[i]);
            chk("R2 R3 table word", bus_rdata, TBL_E[i]);
            chk("R1 table clk_run", clk_run, TBL_C[i]);
        end
        chk("R3 pad_en", pad_en, 1);

        // R12 other address
        @(negedge clk); bus_addr = 4'h3; bus_we = 1'b1; bus_wdata = 16'h0000;
        @(negedge clk); bus_we = 1'b0;
        chk("R12 other addr reads zero", bus_rdata, 0);
        bus_addr = CA;
        tick();
        chk("R12 other addr no write", bus_rdata, 16'h0209);

        // R4 polarity
        chk("R4 pin active high", vbus_pin, 1);
        wr(16'h020D);
        chk("R4 pin inverted", vbus_pin, 0);
        wr(16'h0209);

        // R8 R11 latched cutoff
        @(negedge clk); vbus_err = 1'b1;
        @(negedge clk); vbus_err = 1'b0;
        chk("R8 cutoff", vbus_pin, 0);
        tick();
        chk("R11 cutoff held", vbus_pin, 0);
        wr(16'h2209);
        chk("R11 cutoff cleared", vbus_pin, 1);
        chk("R11 bit13 reads 0", bus_rdata, 16'h0209);
        wr(16'h0289);
        @(negedge clk); vbus_err = 1'b1;
        @(negedge clk); vbus_err = 1'b0;
        chk("R8 manual ignores fault", vbus_pin, 1);

        // R9 interrupt mask
        irq_src = 5'h1F;
        tick();
        chk("R9 mask one", irq_out, 5'b00010);
        wr(16'h1589);
        chk("R9 mask three", irq_out, 5'b10101);
        irq_src = 5'b01010;
        tick();
        chk("R9 masked off", irq_out, 0);

        // R5 device-mode negotiation request
        host_mode = 1'b0;
        wr(16'h0099);
        chk("R5 strobe", hnp_start, 1);
        chk("R5 bit set", bus_rdata[4], 1);
        tick();
        chk("R5 strobe one cycle", hnp_start, 0);
        wr(16'h0089);
        chk("R5 write 0 no effect", bus_rdata[4], 1);
        chk("R5 no re-strobe", hnp_start, 0);
        @(negedge clk); hnp_ack = 1'b1;
        @(negedge clk); hnp_ack = 1'b0;
        chk("R5 ack clears", bus_rdata[4], 0);

        // R7 session request
        wr(16'h00A9);
        chk("R7 strobe", srp_start, 1);
        chk("R7 method data-line", srp_method, 0);
        @(negedge clk); srp_ack = 1'b1;
        @(negedge clk); srp_ack = 1'b0;
        chk("R7 ack clears", bus_rdata[5], 0);
        wr(16'h00E9);
        chk("R7 method vbus", srp_method, 1);
        chk("R7 strobe again", srp_start, 1);
        @(negedge clk); srp_ack = 1'b1;
        @(negedge clk); srp_ack = 1'b0;

        // R6 host-mode accept/reject, R7 host writes ignored
        host_mode = 1'b1;
        wr(16'h00B9);
        chk("R6 accept", hnp_accept, 1);
        chk("R6 no strobe", hnp_start, 0);
        chk("R7 host srp ignored", bus_rdata[5], 0);
        wr(16'h0089);
        chk("R6 reject", hnp_accept, 0);

        finish_run();
    end

endmodule